// File: doc/BRIEF.md
# Serial DAC Code Loader

This block is the digital front end of a 14-bit voltage-output converter. A host writes a 16-bit word over a three-wire serial link: an active-low select, a serial clock and a data line. The word holds a 14-bit code, most significant bit first, followed by two trailing pad bits. The block shifts the bits in while select is low. When select rises, it moves the code into a holding register that drives the parallel code output.

All three serial pins are asynchronous to the system clock. The block oversamples them through synchronizers and detects their edges in the system clock domain. A frame is accepted only if exactly 16 serial clock rising edges arrived while select was low. Any other count leaves the held code untouched and raises a one-cycle error strobe.

An active-low clear input forces the held code to its idle value at once, without waiting for a clock edge. A power-on reset does the same. The idle value depends on a variant parameter: zero for the unipolar build and midscale (8192) for the bipolar build.

Top module: `serial_dac_front`

## Requirements
- R1: After reset, code_o is 0 in the unipolar variant (VARIANT=VAR_UNIPOLAR) and 8192 (0x2000) in the bipolar variant (VARIANT=VAR_BIPOLAR), and upd_o and err_o are low.
- R2: A frame sends 16 bits on din_i, each sampled at a rising edge of sclk_i while cs_ni is low. The order is code bit 13 down to bit 0, then two pad bits. The pad bits are discarded: the first 14 bits become code_o whatever values the pad bits carry.
- R3: code_o changes only after cs_ni rises. A complete 16-bit frame with cs_ni still low leaves code_o unchanged.
- R4: If fewer than 16 serial clock rising edges occur while cs_ni is low, the rising edge of cs_ni leaves code_o unchanged and pulses err_o high for exactly one cycle. upd_o and err_o are never high together.
- R5: If more than 16 serial clock rising edges occur while cs_ni is low, the frame is rejected in the same way as in R4.
- R6: Each accepted frame pulses upd_o high for exactly one system clock cycle, in the cycle in which code_o takes the new value.
- R7: While clr_ni is low, code_o equals the variant's idle code from R1. The clear takes effect asynchronously, with no clock edge needed.
- R8: A clear during a frame also empties the bit count. Bits received before the clear do not count toward the 16, so that frame is rejected as in R4.
- R9: If cs_ni rises while clr_ni is low, the clear wins: code_o keeps the idle code and upd_o stays low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous power-on reset |
| clr_ni | input | 1 | Active-low asynchronous clear of the held code |
| cs_ni | input | 1 | Active-low frame select |
| sclk_i | input | 1 | Serial clock, data sampled on its rising edge |
| din_i | input | 1 | Serial data, most significant bit first |
| code_o | output | 14 | Held code driving the converter |
| upd_o | output | 1 | One-cycle strobe when a frame is accepted |
| err_o | output | 1 | One-cycle strobe when a frame is rejected |

## Verification
The bench builds two copies of the block side by side. dut_i uses the bipolar variant and dut_uni_i the unipolar one, and both receive the same serial, clear and reset stimulus. Because of this, every reset and clear check compares the midscale and zero idle codes in the same run. Frame acceptance, pad-bit discarding and rejection of wrong bit counts are checked on both copies at the same time. The synchronizer depth stays at its default of two stages, and the serial clock is run at several system clocks per half period.

// File: rtl/serial_dac_pkg.sv
package serial_dac_pkg;

  typedef enum logic {
    VAR_UNIPOLAR = 1'b0,
    VAR_BIPOLAR  = 1'b1
  } dac_variant_e;

  // serial pins after sampling, one bit each
  typedef struct packed {
    logic cs_n;
    logic sclk;
    logic din;
  } spi_pins_t;

  localparam spi_pins_t PINS_IDLE = '{cs_n: 1'b1, sclk: 1'b0, din: 1'b0};

endpackage

// File: rtl/sdac_sync.sv
module sdac_sync #(
  parameter int              W       = 3,
  parameter int              STAGES  = 2,
  parameter logic [W-1:0]    RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);

  logic [W-1:0] stg_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < STAGES; i++) stg_q[i] <= RST_VAL;
    end else begin
      stg_q[0] <= d_i;
      for (int i = 1; i < STAGES; i++) stg_q[i] <= stg_q[i-1];
    end
  end

  assign q_o = stg_q[STAGES-1];

endmodule

// File: rtl/sdac_shifter.sv
module sdac_shifter #(
  parameter int DATA_W  = 14,
  parameter int FRAME_W = 16,
  parameter int CNT_W   = 5
) (
  input  logic              clk_i,
  input  logic              arst_ni,
  input  logic              start_i,
  input  logic              sample_i,
  input  logic              din_i,
  output logic [DATA_W-1:0] word_o,
  output logic [CNT_W-1:0]  cnt_o
);

  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [FRAME_W-1:0] sr_q;
  logic [CNT_W-1:0]   cnt_q;

  always_ff @(posedge clk_i or negedge arst_ni) begin
    if (!arst_ni) begin
      sr_q  <= '0;
      cnt_q <= '0;
    end else if (start_i) begin
      cnt_q <= '0;
    end else if (sample_i) begin
      sr_q <= {sr_q[FRAME_W-2:0], din_i};
      // saturate so overlong frames never wrap back to a valid count
      if (cnt_q != CNT_MAX) cnt_q <= cnt_q + 1'b1;
    end
  end

  assign word_o = sr_q[FRAME_W-1 -: DATA_W];
  assign cnt_o  = cnt_q;

endmodule

// File: rtl/sdac_latch.sv
module sdac_latch #(
  parameter int                 DATA_W   = 14,
  parameter int                 FRAME_W  = 16,
  parameter int                 CNT_W    = 5,
  parameter logic [DATA_W-1:0]  RST_CODE = '0
) (
  input  logic              clk_i,
  input  logic              arst_ni,
  input  logic              xfer_i,
  input  logic [DATA_W-1:0] word_i,
  input  logic [CNT_W-1:0]  cnt_i,
  output logic [DATA_W-1:0] code_o,
  output logic              upd_o,
  output logic              err_o
);

  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(FRAME_W);

  logic [DATA_W-1:0] code_q;
  logic              upd_q;
  logic              err_q;

  always_ff @(posedge clk_i or negedge arst_ni) begin
    if (!arst_ni) begin
      code_q <= RST_CODE;
      upd_q  <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      upd_q <= 1'b0;
      err_q <= 1'b0;
      if (xfer_i) begin
        if (cnt_i == CNT_FULL) begin
          code_q <= word_i;
          upd_q  <= 1'b1;
        end else begin
          err_q  <= 1'b1;
        end
      end
    end
  end

  assign code_o = code_q;
  assign upd_o  = upd_q;
  assign err_o  = err_q;

endmodule

// File: rtl/serial_dac_front.sv
module serial_dac_front
  import serial_dac_pkg::*;
#(
  parameter int           DATA_W      = 14,
  parameter int           SUB_W       = 2,
  parameter int           SYNC_STAGES = 2,
  parameter dac_variant_e VARIANT     = VAR_UNIPOLAR
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_ni,
  input  logic              cs_ni,
  input  logic              sclk_i,
  input  logic              din_i,
  output logic [DATA_W-1:0] code_o,
  output logic              upd_o,
  output logic              err_o
);

  localparam int FRAME_W = DATA_W + SUB_W;
  localparam int CNT_W   = $clog2(FRAME_W + 1);
  localparam int PIN_W   = $bits(spi_pins_t);
  localparam logic [DATA_W-1:0] RST_CODE =
    (VARIANT == VAR_BIPOLAR) ? {1'b1, {(DATA_W-1){1'b0}}} : '0;

  spi_pins_t         pins_raw, pins_s;
  logic [PIN_W-1:0]  pins_sync;
  logic              cs_prev_q, sclk_prev_q;
  logic              cs_rise, cs_fall, sclk_rise, sample;
  logic              arst_n;
  logic [DATA_W-1:0] word;
  logic [CNT_W-1:0]  shift_cnt;

  // clear acts like a reset on the frame path and the held code
  assign arst_n = rst_ni & clr_ni;

  assign pins_raw = '{cs_n: cs_ni, sclk: sclk_i, din: din_i};

  sdac_sync #(
    .W       (PIN_W),
    .STAGES  (SYNC_STAGES),
    .RST_VAL (PINS_IDLE)
  ) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (pins_raw),
    .q_o    (pins_sync)
  );

  assign pins_s = spi_pins_t'(pins_sync);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cs_prev_q   <= 1'b1;
      sclk_prev_q <= 1'b0;
    end else begin
      cs_prev_q   <= pins_s.cs_n;
      sclk_prev_q <= pins_s.sclk;
    end
  end

  assign cs_rise   =  pins_s.cs_n & ~cs_prev_q;
  assign cs_fall   = ~pins_s.cs_n &  cs_prev_q;
  assign sclk_rise =  pins_s.sclk & ~sclk_prev_q;
  assign sample    =  sclk_rise & ~pins_s.cs_n;

  sdac_shifter #(
    .DATA_W  (DATA_W),
    .FRAME_W (FRAME_W),
    .CNT_W   (CNT_W)
  ) u_shift (
    .clk_i    (clk_i),
    .arst_ni  (arst_n),
    .start_i  (cs_fall),
    .sample_i (sample),
    .din_i    (pins_s.din),
    .word_o   (word),
    .cnt_o    (shift_cnt)
  );

  sdac_latch #(
    .DATA_W   (DATA_W),
    .FRAME_W  (FRAME_W),
    .CNT_W    (CNT_W),
    .RST_CODE (RST_CODE)
  ) u_latch (
    .clk_i   (clk_i),
    .arst_ni (arst_n),
    .xfer_i  (cs_rise),
    .word_i  (word),
    .cnt_i   (shift_cnt),
    .code_o  (code_o),
    .upd_o   (upd_o),
    .err_o   (err_o)
  );

endmodule

// File: rtl/sdac_checker.sv
module sdac_checker #(
  parameter int                DATA_W   = 14,
  parameter int                FRAME_W  = 16,
  parameter int                CNT_W    = 5,
  parameter logic [DATA_W-1:0] RST_CODE = '0
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              clr_ni,
  input logic [DATA_W-1:0] code_i,
  input logic              upd_i,
  input logic              err_i,
  input logic [CNT_W-1:0]  cnt_i,
  input logic              xfer_i
);

  assert_clear_code_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clr_ni |-> code_i == RST_CODE);

  assert_upd_one_cycle_R6: assert property (@(posedge clk_i) disable iff (!rst_ni || !clr_ni)
    upd_i |=> !upd_i);

  assert_err_one_cycle_R4: assert property (@(posedge clk_i) disable iff (!rst_ni || !clr_ni)
    err_i |=> !err_i);

  assert_upd_err_excl_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(upd_i && err_i));

  assert_upd_full_frame_R2: assert property (@(posedge clk_i) disable iff (!rst_ni || !clr_ni)
    upd_i |-> $past(cnt_i) == CNT_W'(FRAME_W));

  assert_upd_after_cs_rise_R3: assert property (@(posedge clk_i) disable iff (!rst_ni || !clr_ni)
    upd_i |-> $past(xfer_i));

  assert_code_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni || !clr_ni)
    (!upd_i && $past(clr_ni)) |-> $stable(code_i));

endmodule

bind serial_dac_front sdac_checker #(
  .DATA_W   (DATA_W),
  .FRAME_W  (FRAME_W),
  .CNT_W    (CNT_W),
  .RST_CODE (RST_CODE)
) u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .clr_ni (clr_ni),
  .code_i (code_o),
  .upd_i  (upd_o),
  .err_i  (err_o),
  .cnt_i  (shift_cnt),
  .xfer_i (cs_rise)
);

// File: tb/serial_dac_front_tb.sv
module serial_dac_front_tb_top;
  import serial_dac_pkg::*;

  localparam int DW = 14;
  localparam logic [DW-1:0] BI_IDLE  = 14'h2000;
  localparam logic [DW-1:0] UNI_IDLE = 14'h0000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic clr_n = 1'b1;
  logic cs_n = 1'b1;
  logic sclk = 1'b0;
  logic din = 1'b0;

  logic [DW-1:0] code_b, code_u;
  logic upd_b, upd_u, err_b, err_u;

  int checks = 0;
  int errors = 0;
  int upd_cnt_b = 0, upd_cnt_u = 0, err_cnt_b = 0, err_cnt_u = 0;
  logic [DW-1:0] held;

  always #10 clk = ~clk;

  serial_dac_front #(.VARIANT(VAR_BIPOLAR)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .clr_ni(clr_n), .cs_ni(cs_n),
    .sclk_i(sclk), .din_i(din), .code_o(code_b), .upd_o(upd_b), .err_o(err_b));

  serial_dac_front #(.VARIANT(VAR_UNIPOLAR)) dut_uni_i (
    .clk_i(clk), .rst_ni(rst_n), .clr_ni(clr_n), .cs_ni(cs_n),
    .sclk_i(sclk), .din_i(din), .code_o(code_u), .upd_o(upd_u), .err_o(err_u));

  always @(negedge clk) begin
    if (upd_b) upd_cnt_b++;
    if (upd_u) upd_cnt_u++;
    if (err_b) err_cnt_b++;
    if (err_u) err_cnt_u++;
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic cs_low();
    cs_n = 1'b0;
    wait_clk(4);
  endtask

  task automatic cs_high();
    wait_clk(4);
    cs_n = 1'b1;
    wait_clk(10);
  endtask

  task automatic shift_bits(input logic [15:0] w, input int n);
    for (int i = 0; i < n; i++) begin
      din = (i < 16) ? w[15-i] : 1'b0;
      wait_clk(4);
      sclk = 1'b1;
      wait_clk(4);
      sclk = 1'b0;
    end
  endtask

  task automatic frame(input logic [DW-1:0] code, input logic [1:0] pad);
    cs_low();
    shift_bits({code, pad}, 16);
    cs_high();
  endtask

  task automatic t_reset();
    wait_clk(3);
    chk("R1 bipolar idle", code_b, BI_IDLE);
    chk("R1 unipolar idle", code_u, UNI_IDLE);
    chk("R1 strobes low", {upd_b, err_b, upd_u, err_u}, 0);
  endtask

  task automatic t_basic();
    int u0 = upd_cnt_b, u1 = upd_cnt_u, e0 = err_cnt_b;
    frame(14'h2A5C, 2'b00);
    chk("R2 code bipolar", code_b, 14'h2A5C);
    chk("R2 code unipolar", code_u, 14'h2A5C);
    chk("R6 one upd cycle bipolar", upd_cnt_b - u0, 1);
    chk("R6 one upd cycle unipolar", upd_cnt_u - u1, 1);
    chk("R2 no error", err_cnt_b - e0, 0);
  endtask

  task automatic t_wait_for_cs();
    cs_low();
    shift_bits({14'h1234, 2'b00}, 16);
    wait_clk(10);
    chk("R3 held before cs rise", code_b, 14'h2A5C);
    cs_high();
    chk("R3 updated after cs rise", code_b, 14'h1234);
  endtask

  task automatic t_pad_bits();
    frame(14'h3FFF, 2'b11);
    chk("R2 pad ones discarded", code_u, 14'h3FFF);
    frame(14'h0001, 2'b10);
    chk("R2 lsb position", code_b, 14'h0001);
  endtask

  task automatic t_short();
    int e0 = err_cnt_b, u0 = upd_cnt_b;
    held = code_b;
    cs_low();
    shift_bits({14'h0AAA, 2'b00}, 15);
    cs_high();
    chk("R4 short keeps code", code_b, held);
    chk("R4 short err pulse", err_cnt_b - e0, 1);
    chk("R4 short no upd", upd_cnt_b - u0, 0);
    cs_low();
    cs_high();
    chk("R4 empty frame err", err_cnt_b - e0, 2);
    chk("R4 empty keeps code", code_u, held);
  endtask

  task automatic t_long();
    int e0 = err_cnt_u;
    held = code_u;
    cs_low();
    shift_bits({14'h0555, 2'b00}, 17);
    cs_high();
    chk("R5 long keeps code", code_u, held);
    chk("R5 long err pulse", err_cnt_u - e0, 1);
  endtask

  task automatic t_async_clear();
    frame(14'h1555, 2'b00);
    @(posedge clk);
    #4 clr_n = 1'b0;
    #3;
    chk("R7 async clear bipolar", code_b, BI_IDLE);
    chk("R7 async clear unipolar", code_u, UNI_IDLE);
    wait_clk(2);
    clr_n = 1'b1;
    wait_clk(2);
    chk("R7 idle after release", code_b, BI_IDLE);
  endtask

  task automatic t_clear_mid_frame();
    int e0 = err_cnt_b, u0 = upd_cnt_b;
    frame(14'h1555, 2'b00);
    cs_low();
    shift_bits({14'h0F0F, 2'b00}, 8);
    clr_n = 1'b0;
    wait_clk(3);
    chk("R8 cleared mid frame", code_b, BI_IDLE);
    clr_n = 1'b1;
    wait_clk(3);
    shift_bits({8'h0F, 8'h00}, 8);
    cs_high();
    chk("R8 split frame rejected", err_cnt_b - e0, 1);
    chk("R8 only first frame accepted", upd_cnt_b - u0, 1);
    chk("R8 code stays idle", code_u, UNI_IDLE);
  endtask

  task automatic t_clear_priority();
    int u0 = upd_cnt_b, u1 = upd_cnt_u;
    cs_low();
    shift_bits({14'h0ABC, 2'b00}, 16);
    wait_clk(4);
    clr_n = 1'b0;
    wait_clk(2);
    cs_n = 1'b1;
    wait_clk(10);
    chk("R9 clear beats update bipolar", code_b, BI_IDLE);
    chk("R9 clear beats update unipolar", code_u, UNI_IDLE);
    chk("R9 no upd strobe", (upd_cnt_b - u0) + (upd_cnt_u - u1), 0);
    clr_n = 1'b1;
    wait_clk(3);
    frame(14'h0ABC, 2'b01);
    chk("R9 loads after release", code_b, 14'h0ABC);
  endtask

  initial begin
    wait_clk(3);
    rst_n = 1'b1;
    t_reset();
    t_basic();
    t_wait_for_cs();
    t_pad_bits();
    t_short();
    t_long();
    t_async_clear();
    t_clear_mid_frame();
    t_clear_priority();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #2_000_000;
    checks++;
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule